// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This unit executes the atomic instructions of a 32-bit integer core from its execute stage. The pipeline presents a decoded atomic operation, a byte address, the second source operand and a one-cycle start pulse. The unit then runs the operation against a word-wide memory port that uses a request/ready handshake. When it finishes it raises a one-cycle done pulse, and the destination-register value is valid in that cycle. From the start cycle until completion it holds a busy line high so the pipeline freezes.

The unit covers load-reserved, store-conditional and the nine read-modify-write operations. Every read-modify-write reads the old word, writes the combined result and returns the old word. One reservation is held, made of a valid bit and a word address. A load-reserved sets it. A store-conditional consumes it. The reservation is also dropped by a store seen from elsewhere in the core, by an atomic to the reserved word, or by a trap. Control is a four-state Mealy machine with the states idle, read, write and done.

Top module: `amo_unit`

## Requirements
- R1: After reset the unit is idle, with busy, done and mem_req low, and the reservation invalid, so a store-conditional issued first fails.
- R2: The op input encodes 0 load-reserved, 1 store-conditional, 2 swap, 3 add, 4 xor, 5 and, 6 or, 7 signed min, 8 signed max, 9 unsigned min and 10 unsigned max. For codes 2 to 10, rd_value equals the old memory word and the word becomes op(old, rs2). Add wraps modulo 2^32.
- R3: A read-modify-write makes exactly one read and then one write, both to the word-aligned address. With memory that is always ready, done rises 3 cycles after the start cycle, and each wait cycle on a request adds one cycle.
- R4: Load-reserved makes one read and no write, returns the word in rd_value, and sets the reservation on that word address. With zero-wait memory, done comes 2 cycles after start.
- R5: Store-conditional succeeds only if the reservation is valid and its word address matches. On success it writes rs2 and returns 0, with done 2 cycles after start at zero wait. On failure it returns 1, makes no memory request and asserts done in the next cycle.
- R6: Every store-conditional clears the reservation, whether it succeeds or fails.
- R7: An external store (ext_store high) or a read-modify-write to the reserved word clears the reservation. A store to a different word leaves it intact.
- R8: A trap pulse clears the reservation.
- R9: While mem_req is high and mem_ready is low, mem_req, mem_we, mem_addr and mem_wdata hold their values into the next cycle.
- R10: busy is high in the start cycle and in every cycle with a memory request. It is low whenever done is high, and done lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle issue pulse, taken while idle |
| op | input | 4 | Atomic operation code (see R2) |
| addr | input | AW | Byte address of the target word |
| rs2 | input | XLEN | Second source operand |
| ext_store | input | 1 | A store elsewhere in the core is writing memory |
| ext_store_addr | input | AW | Address of that store |
| trap | input | 1 | Trap taken; drops the reservation |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned request address |
| mem_wdata | output | XLEN | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | XLEN | Read data, valid with mem_ready on a read |
| rd_value | output | XLEN | Destination register result |
| done | output | 1 | Operation complete, rd_value valid |
| busy | output | 1 | Pipeline stall request |

## Verification
A wrong state transition shows as a wrong count of read or write handshakes, or as done arriving on a cycle other than the one predicted from the memory wait states. Either is visible in the same operation. A corrupted reservation stays hidden until the next store-conditional, which returns the wrong 0/1 result and writes or fails to write the target word. For this reason every reservation scenario ends with a store-conditional and a check of the memory word. Datapath errors in the combining logic appear as a wrong stored word at the end of the same operation, and then as a wrong old value in the next operation's rd_value.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [3:0] {
    OP_LR   = 4'd0,
    OP_SC   = 4'd1,
    OP_SWAP = 4'd2,
    OP_ADD  = 4'd3,
    OP_XOR  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_MIN  = 4'd7,
    OP_MAX  = 4'd8,
    OP_MINU = 4'd9,
    OP_MAXU = 4'd10
  } amo_op_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_READ  = 2'd1,
    S_WRITE = 2'd2,
    S_DONE  = 2'd3
  } amo_st_e;

  function automatic logic is_rmw(input amo_op_e o);
    return (o != OP_LR) && (o != OP_SC);
  endfunction

endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  amo_op_e           op,
  input  logic [XLEN-1:0]   old_val,
  input  logic [XLEN-1:0]   operand,
  output logic [XLEN-1:0]   result
);

  logic lt_s;
  logic lt_u;

  assign lt_s = $signed(old_val) < $signed(operand);
  assign lt_u = old_val < operand;

  always_comb begin
    unique case (op)
      OP_ADD:  result = old_val + operand;
      OP_XOR:  result = old_val ^ operand;
      OP_AND:  result = old_val & operand;
      OP_OR:   result = old_val | operand;
      OP_MIN:  result = lt_s ? old_val : operand;
      OP_MAX:  result = lt_s ? operand : old_val;
      OP_MINU: result = lt_u ? old_val : operand;
      OP_MAXU: result = lt_u ? operand : old_val;
      default: result = operand;
    endcase
  end

endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int AW = 32,
  localparam int WAW = AW - 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           set,
  input  logic [WAW-1:0] set_word,
  input  logic           sc_issue,
  input  logic           rmw_issue,
  input  logic [WAW-1:0] issue_word,
  input  logic           ext_store,
  input  logic [WAW-1:0] ext_word,
  input  logic           trap,
  output logic           hit
);

  logic           valid_q;
  logic [WAW-1:0] word_q;
  logic           kill;

  assign hit  = valid_q && (word_q == issue_word);

  assign kill = sc_issue || trap
             || (ext_store && (ext_word == word_q))
             || (rmw_issue && (issue_word == word_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      if (set) begin
        valid_q <= 1'b1;
        word_q  <= set_word;
      end
      if (kill) begin
        valid_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 32,
  localparam int WAW = AW - 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  amo_op_e         op,
  input  logic [WAW-1:0]  word,
  input  logic [XLEN-1:0] rs2,
  input  logic            resv_hit,
  input  logic            mem_ready,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic [XLEN-1:0] alu_y,
  output amo_op_e         alu_op,
  output logic [XLEN-1:0] alu_b,
  output logic            lr_set,
  output logic [WAW-1:0]  lr_word,
  output logic            sc_issue,
  output logic            rmw_issue,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic [XLEN-1:0] rd_value,
  output logic            done,
  output logic            busy
);

  amo_st_e         st_q;
  amo_op_e         op_q;
  logic [WAW-1:0]  word_q;
  logic [XLEN-1:0] rs2_q;
  logic [XLEN-1:0] wdata_q;
  logic [XLEN-1:0] rd_q;
  logic            idle;
  logic            take;

  assign idle      = (st_q == S_IDLE);
  assign take      = idle && start;
  assign sc_issue  = take && (op == OP_SC);
  assign rmw_issue = take && is_rmw(op);

  assign alu_op    = op_q;
  assign alu_b     = rs2_q;

  assign lr_set    = (st_q == S_READ) && mem_ready && (op_q == OP_LR);
  assign lr_word   = word_q;

  assign mem_req   = (st_q == S_READ) || (st_q == S_WRITE);
  assign mem_we    = (st_q == S_WRITE);
  assign mem_addr  = {word_q, 2'b00};
  assign mem_wdata = wdata_q;
  assign rd_value  = rd_q;
  assign done      = (st_q == S_DONE);
  assign busy      = mem_req || take;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      op_q    <= OP_LR;
      word_q  <= '0;
      rs2_q   <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (start) begin
            op_q   <= op;
            word_q <= word;
            rs2_q  <= rs2;
            if (op == OP_SC) begin
              if (resv_hit) begin
                wdata_q <= rs2;
                rd_q    <= '0;
                st_q    <= S_WRITE;
              end else begin
                rd_q <= XLEN'(1);
                st_q <= S_DONE;
              end
            end else begin
              st_q <= S_READ;
            end
          end
        end
        S_READ: begin
          if (mem_ready) begin
            rd_q <= mem_rdata;
            if (op_q == OP_LR) begin
              st_q <= S_DONE;
            end else begin
              wdata_q <= alu_y;
              st_q    <= S_WRITE;
            end
          end
        end
        S_WRITE: begin
          if (mem_ready) begin
            st_q <= S_DONE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [3:0]      op,
  input  logic [AW-1:0]   addr,
  input  logic [XLEN-1:0] rs2,
  input  logic            ext_store,
  input  logic [AW-1:0]   ext_store_addr,
  input  logic            trap,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ready,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] rd_value,
  output logic            done,
  output logic            busy
);

  localparam int WAW = AW - 2;

  amo_op_e         op_e;
  amo_op_e         alu_op;
  logic [XLEN-1:0] alu_b;
  logic [XLEN-1:0] alu_y;
  logic            lr_set;
  logic [WAW-1:0]  lr_word;
  logic            sc_issue;
  logic            rmw_issue;
  logic            resv_hit;
  logic [1:0]      unused_low;

  assign op_e       = amo_op_e'(op);
  assign unused_low = addr[1:0] ^ ext_store_addr[1:0];

  amo_alu #(.XLEN(XLEN)) i_alu (
    .op      (alu_op),
    .old_val (mem_rdata),
    .operand (alu_b),
    .result  (alu_y)
  );

  amo_resv #(.AW(AW)) i_resv (
    .clk        (clk),
    .rst        (rst),
    .set        (lr_set),
    .set_word   (lr_word),
    .sc_issue   (sc_issue),
    .rmw_issue  (rmw_issue),
    .issue_word (addr[AW-1:2]),
    .ext_store  (ext_store),
    .ext_word   (ext_store_addr[AW-1:2]),
    .trap       (trap),
    .hit        (resv_hit)
  );

  amo_ctrl #(.XLEN(XLEN), .AW(AW)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op        (op_e),
    .word      (addr[AW-1:2]),
    .rs2       (rs2),
    .resv_hit  (resv_hit),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .alu_y     (alu_y),
    .alu_op    (alu_op),
    .alu_b     (alu_b),
    .lr_set    (lr_set),
    .lr_word   (lr_word),
    .sc_issue  (sc_issue),
    .rmw_issue (rmw_issue),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rd_value  (rd_value),
    .done      (done),
    .busy      (busy)
  );

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int XLEN = 32,
  parameter int AW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [3:0]      op,
  input logic            trap,
  input logic            mem_req,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic [XLEN-1:0] mem_wdata,
  input logic            mem_ready,
  input logic            done,
  input logic            busy,
  input logic            ctrl_idle,
  input logic            resv_hit,
  input logic            resv_valid
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_REQ_MEANS_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy); // R10

  AST_SC_MISS_SHORT: assert property (@(posedge clk) disable iff (rst)
    ctrl_idle && start && (op == 4'd1) && !resv_hit |=> done && !mem_req); // R5

  AST_SC_DROPS_RESV: assert property (@(posedge clk) disable iff (rst)
    ctrl_idle && start && (op == 4'd1) |=> !resv_valid); // R6

  AST_TRAP_DROPS_RESV: assert property (@(posedge clk) disable iff (rst)
    trap |=> !resv_valid); // R8

endmodule

bind amo_unit amo_unit_chk #(.XLEN(XLEN), .AW(AW)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .op         (op),
  .trap       (trap),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ready  (mem_ready),
  .done       (done),
  .busy       (busy),
  .ctrl_idle  (i_ctrl.idle),
  .resv_hit   (resv_hit),
  .resv_valid (i_resv.valid_q)
);

// File: tb/test_amo_unit.sv
module test_amo_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  idx;
    logic [31:0] rs2;
    logic [31:0] exp_rd;
    logic [31:0] exp_mem;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd2,  4'd1, 32'h0000_0005, 32'h0000_0010, 32'h0000_0005},
    '{4'd3,  4'd1, 32'h0000_0007, 32'h0000_0005, 32'h0000_000C},
    '{4'd4,  4'd1, 32'h0000_000F, 32'h0000_000C, 32'h0000_0003},
    '{4'd6,  4'd1, 32'h0000_0030, 32'h0000_0003, 32'h0000_0033},
    '{4'd5,  4'd1, 32'h0000_0021, 32'h0000_0033, 32'h0000_0021},
    '{4'd7,  4'd2, 32'h0000_0005, 32'hFFFF_FFF0, 32'hFFFF_FFF0},
    '{4'd9,  4'd2, 32'h0000_0005, 32'hFFFF_FFF0, 32'h0000_0005},
    '{4'd8,  4'd2, 32'hFFFF_FFFF, 32'h0000_0005, 32'h0000_0005},
    '{4'd10, 4'd2, 32'hFFFF_FFFF, 32'h0000_0005, 32'hFFFF_FFFF},
    '{4'd7,  4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{4'd8,  4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF},
    '{4'd3,  4'd2, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000},
    '{4'd0,  4'd1, 32'h0000_0000, 32'h0000_0021, 32'h0000_0021},
    '{4'd1,  4'd1, 32'h0000_00AB, 32'h0000_0000, 32'h0000_00AB},
    '{4'd1,  4'd1, 32'h0000_00CD, 32'h0000_0001, 32'h0000_00AB}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] addr_i = '0;
  logic [31:0] rs2_i = '0;
  logic        ext_store = 1'b0;
  logic [31:0] ext_store_addr = '0;
  logic        trap = 1'b0;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ready;
  logic [31:0] mem_rdata;
  logic [31:0] rd_value;
  logic        done;
  logic        busy;

  logic [31:0] mem [16];
  int lat_cfg = 0;
  int wcnt = 0;
  int nrd = 0;
  int nwr = 0;
  int nviol = 0;
  int ndb = 0;
  logic        pend = 1'b0;
  logic        pw = 1'b0;
  logic [31:0] pa = '0;
  logic [31:0] pd = '0;

  int nchk = 0;
  int nbad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amo_unit i_amo_unit (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .op             (op_i),
    .addr           (addr_i),
    .rs2            (rs2_i),
    .ext_store      (ext_store),
    .ext_store_addr (ext_store_addr),
    .trap           (trap),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_ready      (mem_ready),
    .mem_rdata      (mem_rdata),
    .rd_value       (rd_value),
    .done           (done),
    .busy           (busy)
  );

  assign mem_ready = mem_req && (wcnt >= lat_cfg);
  assign mem_rdata = mem[mem_addr[5:2]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'h0000_1000 + 32'(i);
      mem[1] <= 32'h0000_0010;
      mem[2] <= 32'hFFFF_FFF0;
      wcnt <= 0;
      pend <= 1'b0;
    end else begin
      if (pend && !(mem_req && mem_we == pw && mem_addr == pa && mem_wdata == pd))
        nviol <= nviol + 1;
      if (busy && done) ndb <= ndb + 1;
      pend <= mem_req && !mem_ready;
      pw   <= mem_we;
      pa   <= mem_addr;
      pd   <= mem_wdata;
      if (mem_req && mem_ready) begin
        wcnt <= 0;
        if (mem_we) begin
          mem[mem_addr[5:2]] <= mem_wdata;
          nwr <= nwr + 1;
        end else begin
          nrd <= nrd + 1;
        end
      end else if (mem_req) begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input int idx, input logic [31:0] r, input int lat,
                        output logic [31:0] res, output int cyc, output int rds, output int wrs,
                        output logic bz_start, output logic bz_done);
    int r0;
    int w0;
    @(negedge clk);
    lat_cfg = lat;
    op_i    = o;
    addr_i  = 32'(idx * 4);
    rs2_i   = r;
    start   = 1'b1;
    r0 = nrd;
    w0 = nwr;
    #1 bz_start = busy;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    bz_done = busy;
    res = rd_value;
    rds = nrd - r0;
    wrs = nwr - w0;
  endtask

  task automatic pulse(input bit is_trap, input int idx);
    @(negedge clk);
    if (is_trap) trap = 1'b1;
    else begin
      ext_store = 1'b1;
      ext_store_addr = 32'(idx * 4);
    end
    @(negedge clk);
    trap = 1'b0;
    ext_store = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] res;
    int cyc;
    int rds;
    int wrs;
    logic b0;
    logic b1;
    int ecyc;
    int erd;
    int ewr;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    // R1: no reservation after reset, SC to word 5 fails
    run_op(4'd1, 5, 32'hDEAD_0000, 0, res, cyc, rds, wrs, b0, b1);
    chk("R1 sc after reset rd", res, 32'd1);
    chk("R1 sc after reset mem", mem[5], 32'h0000_1005);

    for (int i = 0; i < NVEC; i++) begin
      int lat;
      lat = i % 3;
      run_op(VECS[i].op, int'(VECS[i].idx), VECS[i].rs2, lat, res, cyc, rds, wrs, b0, b1);
      if (VECS[i].op == 4'd0) begin
        ecyc = 2 + lat; erd = 1; ewr = 0;
      end else if (VECS[i].op == 4'd1 && VECS[i].exp_rd == 32'd0) begin
        ecyc = 2 + lat; erd = 0; ewr = 1;
      end else if (VECS[i].op == 4'd1) begin
        ecyc = 1; erd = 0; ewr = 0;
      end else begin
        ecyc = 3 + 2 * lat; erd = 1; ewr = 1;
      end
      chk($sformatf("R2 vec%0d rd", i), res, VECS[i].exp_rd);
      chk($sformatf("R2 vec%0d mem", i), mem[VECS[i].idx], VECS[i].exp_mem);
      chk($sformatf("R3 vec%0d cycles", i), 32'(cyc), 32'(ecyc));
      chk($sformatf("R3 vec%0d reads", i), 32'(rds), 32'(erd));
      chk($sformatf("R3 vec%0d writes", i), 32'(wrs), 32'(ewr));
      chk($sformatf("R10 vec%0d busy at start", i), 32'(b0), 32'd1);
      chk($sformatf("R10 vec%0d busy at done", i), 32'(b1), 32'd0);
    end

    // R4: LR word 3 returns its value in 2 cycles at zero wait
    run_op(4'd0, 3, 32'd0, 0, res, cyc, rds, wrs, b0, b1);
    chk("R4 lr rd", res, 32'h0000_1003);
    chk("R4 lr cycles", 32'(cyc), 32'd2);
    // R7: RMW to the reserved word drops the reservation
    run_op(4'd3, 3, 32'd1, 0, res, cyc, rds, wrs, b0, b1);
    chk("R7 rmw rd", res, 32'h0000_1003);
    run_op(4'd1, 3, 32'h55, 0, res, cyc, rds, wrs, b0, b1);
    chk("R7 sc after rmw rd", res, 32'd1);
    chk("R7 sc after rmw mem", mem[3], 32'h0000_1004);
    chk("R5 failed sc no access", 32'(rds + wrs), 32'd0);

    // R7: external store to reserved word
    run_op(4'd0, 3, 32'd0, 1, res, cyc, rds, wrs, b0, b1);
    pulse(1'b0, 3);
    run_op(4'd1, 3, 32'h66, 0, res, cyc, rds, wrs, b0, b1);
    chk("R7 sc after store rd", res, 32'd1);
    chk("R7 sc after store mem", mem[3], 32'h0000_1004);

    // R7: external store to another word keeps it
    run_op(4'd0, 3, 32'd0, 0, res, cyc, rds, wrs, b0, b1);
    pulse(1'b0, 4);
    run_op(4'd1, 3, 32'h77, 0, res, cyc, rds, wrs, b0, b1);
    chk("R7 sc after other store rd", res, 32'd0);
    chk("R7 sc after other store mem", mem[3], 32'h0000_0077);
    chk("R5 sc success cycles", 32'(cyc), 32'd2);

    // R8: trap drops the reservation
    run_op(4'd0, 3, 32'd0, 0, res, cyc, rds, wrs, b0, b1);
    chk("R4 lr after sc rd", res, 32'h0000_0077);
    pulse(1'b1, 0);
    run_op(4'd1, 3, 32'h99, 0, res, cyc, rds, wrs, b0, b1);
    chk("R8 sc after trap rd", res, 32'd1);
    chk("R8 sc after trap mem", mem[3], 32'h0000_0077);

    // R5: address mismatch fails; R6: failed SC still clears
    run_op(4'd0, 3, 32'd0, 2, res, cyc, rds, wrs, b0, b1);
    run_op(4'd1, 4, 32'h88, 0, res, cyc, rds, wrs, b0, b1);
    chk("R5 sc mismatch rd", res, 32'd1);
    chk("R5 sc mismatch mem", mem[4], 32'h0000_1004);
    chk("R5 sc mismatch cycles", 32'(cyc), 32'd1);
    run_op(4'd1, 3, 32'hAA, 0, res, cyc, rds, wrs, b0, b1);
    chk("R6 sc after failed sc rd", res, 32'd1);
    chk("R6 sc after failed sc mem", mem[3], 32'h0000_0077);

    // R9 / R10: monitors across all traffic
    chk("R9 request held while waiting", 32'(nviol), 32'd0);
    chk("R10 busy with done", 32'(ndb), 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule